// File: doc/BRIEF.md
# Keyboard Matrix Response Emulator

This block lets a host keyboard scanner believe it is driving a real key matrix. Key events arrive as bytes, where bit 7 set means the key was released and bit 7 clear means it was pressed. They go into a small queue. A tick generator paces the queue so that at most one byte is applied per tick period. The host drives strobe (column) lines. The block answers on sense (row) lines, from a per-row bitmap of pressed keys. There is no internal scanning: each sense line reflects whichever pressed keys sit in the columns the host is currently strobing.

The translation from byte to matrix position lives outside the block. The block presents the low seven bits of the oldest queued byte on `lut_idx`. An external lookup answers combinationally with a position code, whose upper nibble is the row and lower nibble is the column, together with a hit flag. A miss means the key has no place in the matrix. Row 7, one past the last sense row, is not part of the matrix. A key in row 7 with column c drives discrete switch output c, and each switch line has its own polarity-invert input.

A one-cycle `restore` pulse puts the block back in a known state. It releases every key and switch, discards the queued bytes and clears the overflow flag.

Control is a two-state machine. `ST_IDLE` waits, and moves to `ST_APPLY` when a tick arrives while the queue holds data and no restore is requested. `ST_APPLY` lasts exactly one cycle. In that cycle the head byte is looked up, applied to the bitmap or switches, and popped. The machine then always returns to `ST_IDLE`. A restore forces `ST_IDLE` and cancels the pop.

Top module: `keymat_emu`

## Requirements
- R1: After reset, `sense_out` is all zero, `overflow` is low, the queue is empty and `switch_out` equals `sw_invert`.
- R2: `sense_out[i]` is registered. One cycle after any change, it equals the OR of (pressed mask of row i AND `strobe_in`).
- R3: An applied byte with bit 7 clear sets the key at lookup row `lut_code[7:4]` and column `lut_code[3:0]`, when row < 7 and column < 11. An applied byte with bit 7 set clears that key.
- R4: An applied byte changes no matrix key and no switch in any of these cases: `lut_hit` is low; the column is 11 or more in rows 0 to 6; the row is 8 or more; the row is 7 and the column is 5 or more.
- R5: `lut_idx` carries bits 6:0 of the oldest byte held in the queue.
- R6: At most one queued byte is applied per tick. Ticks come every `TICK_CYCLES` clock cycles, so two queued bytes take effect exactly `TICK_CYCLES` cycles apart.
- R7: The queue holds 16 bytes and applies them in arrival order. A byte offered while 16 are held is dropped and sets `overflow`, which stays high until a restore.
- R8: A pressed key at row 7, column c < 5, makes `switch_out[c]` equal to 1 XOR `sw_invert[c]`. A released key there makes it equal to `sw_invert[c]`.
- R9: A `restore` pulse releases all keys and switches and empties the queue, so queued bytes are never applied. It also clears `overflow`, and `sense_out` goes low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restore | input | 1 | One-cycle state restore: release all, flush queue |
| in_valid | input | 1 | Key byte offered this cycle |
| in_byte | input | 8 | Key byte; bit 7 = release |
| overflow | output | 1 | Sticky: a byte was dropped on a full queue |
| lut_idx | output | 7 | Lookup index from the queue head |
| lut_code | input | 8 | Lookup result: row in [7:4], column in [3:0] |
| lut_hit | input | 1 | Lookup result is valid (low = ignore key) |
| strobe_in | input | N_STROBE | Host-driven column strobes |
| sense_out | output | N_SENSE | Registered row sense answers |
| sw_invert | input | N_SWITCH | Per-switch polarity invert |
| switch_out | output | N_SWITCH | Discrete switch lines from row 7 |

## Verification
The hardest state to reach is a byte arriving exactly when the queue holds sixteen entries. The tick phase is hidden and keeps draining the queue. To get there, the bench first queues a single marker key and waits for its sense line to rise. That reveals a tick boundary and leaves almost a whole tick period with no pop. Seventeen bytes are then offered back to back, and the drop is proved at the ports: the seventeenth key never shows on sense, and `overflow` stays set. The same tick-locating trick measures the spacing between two applications. An exhaustive sweep of all 128 lookup indices covers the presses, releases, ignored positions and switch row.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

    // Two-phase apply controller
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } apply_state_t;

    // Position code returned by the external lookup
    typedef struct packed {
        logic [3:0] row;
        logic [3:0] col;
    } key_pos_t;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;

endpackage

// File: rtl/keymat_tick.sv
module keymat_tick #(
    parameter int PERIOD = 1562500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: ticks are never back to back, so one apply cycle cannot swallow one
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/keymat_fifo.sv
module keymat_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, wr_en, rd_en, ovf_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt_q == FULL_CNT);
    assign empty    = (cnt_q == '0);
    assign wr_en    = push && !full && !clear;
    assign rd_en    = pop && !empty && !clear;
    assign dout     = mem_q[rp_q];
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= bump(wp_q);
            if (rd_en) rp_q <= bump(rp_q);
            unique case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ovf_q <= 1'b0;
        end else if (push && full) begin
            ovf_q <= 1'b1;
        end
    end

    // R7: a byte offered to a full queue raises the sticky flag
    assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> overflow);
    // R7: a full queue that is not drained stays full (the byte was dropped)
    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> (cnt_q == FULL_CNT));
    // R9: restore empties the queue and clears the flag
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && !overflow));
    // R6: the controller only pops a queue that holds data
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/keymat_matrix.sv
module keymat_matrix
    import keymat_pkg::*;
#(
    parameter int N_STROBE = 11,
    parameter int N_SENSE  = 7,
    parameter int N_SWITCH = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                ev_valid,
    input  logic                ev_release,
    input  key_pos_t            ev_pos,
    input  logic [N_STROBE-1:0] strobe_in,
    input  logic [N_SWITCH-1:0] sw_invert,
    output logic [N_SENSE-1:0]  sense_out,
    output logic [N_SWITCH-1:0] switch_out
);
    localparam logic [3:0] SW_ROW = 4'(N_SENSE);

    logic [N_STROBE-1:0] mask_q [N_SENSE];
    logic [N_STROBE-1:0] col_hot;
    logic [N_SWITCH-1:0] sw_hot, sw_q;
    logic [N_SENSE-1:0]  sense_d, sense_q;

    // Out-of-range columns shift the one-hot bit out: no key is touched
    assign col_hot = N_STROBE'(1) << ev_pos.col;
    assign sw_hot  = N_SWITCH'(1) << ev_pos.col;

    for (genvar r = 0; r < N_SENSE; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mask_q[r] <= '0;
            end else if (ev_valid && ev_pos.row == 4'(r)) begin
                mask_q[r] <= ev_release ? (mask_q[r] & ~col_hot)
                                        : (mask_q[r] | col_hot);
            end
        end

        // R2: a row with no pressed key never senses
        assert_idle_row_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[r] == '0) |=> !sense_out[r]);
        // R9: restore releases every key of the row
        assert_clear_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (mask_q[r] == '0));
        // R4: columns past the strobe count leave the row untouched
        assert_bad_col_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(ev_pos.col) >= N_STROBE && !clear) |=> (mask_q[r] == $past(mask_q[r])));
    end

    always_comb begin
        for (int r = 0; r < N_SENSE; r++) begin
            sense_d[r] = |(mask_q[r] & strobe_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else begin
            sense_q <= sense_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sw_q <= '0;
        end else if (ev_valid && ev_pos.row == SW_ROW) begin
            sw_q <= ev_release ? (sw_q & ~sw_hot) : (sw_q | sw_hot);
        end
    end

    assign sense_out  = sense_q;
    assign switch_out = sw_q ^ sw_invert;

    for (genvar s = 0; s < N_SWITCH; s++) begin : g_sw
        // R8: a press on the switch row latches that switch
        assert_switch_press_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && !ev_release && !clear && ev_pos.row == SW_ROW
             && ev_pos.col == 4'(s)) |=> (switch_out[s] != sw_invert[s]));
    end

    // R2: with every strobe low, all sense lines drop one cycle later
    assert_strobe_low_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_in == '0) |=> (sense_out == '0));
    // R9: restore releases the switches
    assert_clear_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sw_q == '0));

endmodule

// File: rtl/keymat_emu.sv
module keymat_emu
    import keymat_pkg::*;
#(
    parameter int N_STROBE    = 11,
    parameter int N_SENSE     = 7,
    parameter int N_SWITCH    = 5,
    parameter int FIFO_DEPTH  = 16,
    parameter int TICK_CYCLES = 1562500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restore,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    output logic                overflow,
    output logic [6:0]          lut_idx,
    input  logic [7:0]          lut_code,
    input  logic                lut_hit,
    input  logic [N_STROBE-1:0] strobe_in,
    output logic [N_SENSE-1:0]  sense_out,
    input  logic [N_SWITCH-1:0] sw_invert,
    output logic [N_SWITCH-1:0] switch_out
);
    apply_state_t      state_q, state_d;
    logic              tick;
    logic              q_pop, q_empty;
    logic [BYTE_W-1:0] q_head;
    logic              ev_valid, ev_release;
    key_pos_t          ev_pos;

    keymat_tick #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    keymat_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restore),
        .push     (in_valid),
        .din      (in_byte),
        .pop      (q_pop),
        .dout     (q_head),
        .empty    (q_empty),
        .overflow (overflow)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!restore && tick && !q_empty) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        q_pop      = (state_q == ST_APPLY) && !restore;
        ev_valid   = q_pop && lut_hit;
        ev_release = q_head[BYTE_W-1];
        ev_pos     = key_pos_t'(lut_code);
        lut_idx    = q_head[IDX_W-1:0];
    end

    keymat_matrix #(
        .N_STROBE (N_STROBE),
        .N_SENSE  (N_SENSE),
        .N_SWITCH (N_SWITCH)
    ) u_matrix (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restore),
        .ev_valid   (ev_valid),
        .ev_release (ev_release),
        .ev_pos     (ev_pos),
        .strobe_in  (strobe_in),
        .sw_invert  (sw_invert),
        .sense_out  (sense_out),
        .switch_out (switch_out)
    );

    // R6: a byte is applied only in the cycle right after a tick
    assert_apply_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |-> $past(tick));
    // R6: the apply state never lasts two cycles
    assert_single_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_keymat_emu.sv
module test_keymat_emu;
    localparam int TC = 40;
    localparam logic [4:0] INV = 5'b10110;

    logic        clk = 1'b0;
    logic        rst_n, restore, in_valid, lut_hit, overflow;
    logic [7:0]  in_byte, lut_code;
    logic [6:0]  lut_idx;
    logic [10:0] strobe;
    logic [6:0]  sense_out;
    logic [4:0]  switch_out;

    always #4 clk = ~clk;

    keymat_emu #(.TICK_CYCLES(TC)) i_keymat_emu (
        .clk        (clk),
        .rst_n      (rst_n),
        .restore    (restore),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .overflow   (overflow),
        .lut_idx    (lut_idx),
        .lut_code   (lut_code),
        .lut_hit    (lut_hit),
        .strobe_in  (strobe),
        .sense_out  (sense_out),
        .sw_invert  (INV),
        .switch_out (switch_out)
    );

    // Arithmetic lookup: row = idx mod 9, column = (idx / 9) mod 13, miss when idx mod 13 == 12
    always_comb begin
        lut_hit  = (int'(lut_idx) % 13) != 12;
        lut_code = {4'(int'(lut_idx) % 9), 4'((int'(lut_idx) / 9) % 13)};
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [10:0] exp_mask [7];
    logic [4:0]  exp_sw;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < 7; r++) exp_mask[r] = '0;
        exp_sw = '0;
    endtask

    task automatic model_apply(input logic [7:0] b);
        int idx, row, col;
        idx = int'(b[6:0]);
        if (idx % 13 != 12) begin
            row = idx % 9;
            col = (idx / 9) % 13;
            if (row < 7 && col < 11) exp_mask[row][col] = !b[7];
            else if (row == 7 && col < 5) exp_sw[col] = !b[7];
        end
    endtask

    function automatic logic [6:0] exp_sense(input logic [10:0] s);
        logic [6:0] v;
        for (int r = 0; r < 7; r++) v[r] = |(exp_mask[r] & s);
        return v;
    endfunction

    // Sweeps strobe patterns; sense sampled one cycle after each change (R2)
    task automatic check_matrix(input string tag);
        for (int c = -1; c <= 11; c++) begin
            logic [10:0] s;
            s = (c < 0) ? 11'd0 : (c == 11) ? 11'h7ff : (11'd1 << c);
            strobe = s;
            @(negedge clk);
            chk(sense_out == exp_sense(s), {tag, " R2"}, "sense", int'(sense_out), int'(exp_sense(s)));
        end
        chk(switch_out == (exp_sw ^ INV), tag, "switch", int'(switch_out), int'(exp_sw ^ INV));
        strobe = '1;
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_restore();
        restore = 1'b1;
        @(negedge clk);
        restore = 1'b0;
        model_clear();
    endtask

    initial begin
        rst_n = 1'b0; restore = 1'b0; in_valid = 1'b0; in_byte = '0; strobe = '1;
        model_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(sense_out == '0, "R1", "sense", int'(sense_out), 0);
        chk(overflow == 1'b0, "R1", "overflow", int'(overflow), 0);
        chk(switch_out == INV, "R1", "switch", int'(switch_out), int'(INV));
        check_matrix("R1");

        // R3 R4 R5 R8: every lookup index pressed and released
        for (int idx = 0; idx < 128; idx++) begin
            push({1'b0, 7'(idx)});
            chk(lut_idx == 7'(idx), "R5", "lut_idx", int'(lut_idx), idx);
            model_apply({1'b0, 7'(idx)});
            repeat (2 * TC + 4) @(negedge clk);
            check_matrix("R3 R4 R8 press");
            push({1'b1, 7'(idx)});
            model_apply({1'b1, 7'(idx)});
            repeat (2 * TC + 4) @(negedge clk);
            check_matrix("R3 R4 R8 release");
        end

        // R6: two queued bytes take effect TICK_CYCLES apart
        begin
            int cyc, ta, tb;
            pulse_restore();
            repeat (4) @(negedge clk);
            push(8'h00); model_apply(8'h00);
            push(8'h01); model_apply(8'h01);
            cyc = 0; ta = -1; tb = -1;
            while ((ta < 0 || tb < 0) && cyc < 4 * TC) begin
                @(negedge clk);
                cyc++;
                if (sense_out[0] && ta < 0) ta = cyc;
                if (sense_out[1] && tb < 0) tb = cyc;
            end
            chk(tb - ta == TC, "R6", "apply spacing", tb - ta, TC);
        end

        // R7: locate a tick via a marker key, then offer 17 bytes within one period
        begin
            int cyc;
            pulse_restore();
            repeat (4) @(negedge clk);
            push(8'h00); model_apply(8'h00);
            cyc = 0;
            while (!sense_out[0] && cyc < 3 * TC) begin
                @(negedge clk);
                cyc++;
            end
            for (int k = 1; k <= 16; k++) begin
                push({1'b0, 7'(k)});
                model_apply({1'b0, 7'(k)});
            end
            push(8'd19);  // 17th byte: must be dropped (row 1, column 2 stays released)
            chk(overflow == 1'b1, "R7", "overflow", int'(overflow), 1);
            repeat (18 * TC) @(negedge clk);
            check_matrix("R7 full queue");
            chk(overflow == 1'b1, "R7", "overflow sticky", int'(overflow), 1);
        end

        // R7: arrival order is kept
        push(8'd20);        model_apply(8'd20);
        push(8'h80 | 8'd20); model_apply(8'h80 | 8'd20);
        push(8'h80 | 8'd1);  model_apply(8'h80 | 8'd1);
        push(8'd1);          model_apply(8'd1);
        repeat (6 * TC) @(negedge clk);
        check_matrix("R7 order");

        // R9: restore with a switch held and a full queue pending
        push(8'd7); model_apply(8'd7);
        repeat (2 * TC + 4) @(negedge clk);
        check_matrix("R9 before restore");
        for (int k = 30; k < 47; k++) push({1'b0, 7'(k)});
        pulse_restore();
        chk(overflow == 1'b0, "R9", "overflow cleared", int'(overflow), 0);
        @(negedge clk);
        chk(sense_out == '0, "R9", "sense after restore", int'(sense_out), 0);
        repeat (20 * TC) @(negedge clk);
        check_matrix("R9 flushed");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule